// File: doc/BRIEF.md
# Widening Vector Left Shift Unit

This block decodes and executes a widening left shift on a 64-bit vector. An instruction word arrives with a 64-bit source vector value. The word is in one of two forms: a shift-immediate form or a maximum-shift form. In the shift-immediate form, one 6-bit immediate carries both the element width and the shift amount. In the maximum-shift form, a 2-bit size field picks the element width and the shift always equals that width. The block splits the source into 8-, 16- or 32-bit elements. It sign- or zero-extends each element to twice its width, shifts it left, and packs the lanes into a 128-bit result.

The block also reports the destination register number of the 128-bit result. It flags encodings that are undefined. It refuses immediate values that belong to other operations: these raise neither flag and produce no result. Every lane is computed in parallel for all three widths, and the result is then selected, so the timing never depends on the data.

The `OUT_REG` parameter sets where the result appears:
- With `OUT_REG` = 1 (the default), the result is registered and appears one cycle after the input.
- With `OUT_REG` = 0, the result appears in the same cycle as the input.

Top module: `widen_shift_unit`

## Requirements
- R1: Shift-immediate form (instr[4]=1). The immediate is imm6 = instr[21:16]. The element width comes from the highest set bit among imm6[5:3]: 001 gives 8, 01x gives 16 and 1xx gives 32. The shift amount is imm6 minus the element width.
- R2: In the shift-immediate form, if imm6[5:3] = 000 the operation is not this one. The outputs are then out_valid=0, out_undef=0, out_dst=0 and out_vec=0.
- R3: In the shift-immediate form, imm6 values 001000, 010000 and 100000 give a zero shift and are refused in the same way as in R2.
- R4: In the shift-immediate form, instr[24]=1 zero-extends each element and instr[24]=0 sign-extends it, before the shift.
- R5: Maximum-shift form (instr[4]=0). The size field instr[19:18] gives 00→8, 01→16 and 10→32 bits. The shift equals the element width. The result does not depend on instr[24].
- R6: In the maximum-shift form, a size field of 11 raises out_undef with out_valid=0 and a zero result.
- R7: In both forms, instr[12]=1 (an odd destination index) raises out_undef with out_valid=0. R2 and R3 take precedence over this rule.
- R8: Lane e holds the low 2×width bits of the extended, shifted element e, at bit offset e×2×width. The number of lanes is 64 divided by the width.
- R9: out_dst is {instr[22], instr[15:13]}, which is the destination index {D,Vd} divided by two.
- R10: With in_valid=0, all outputs are zero. With OUT_REG=1, outputs follow inputs after one clock edge and are zero during reset. With OUT_REG=0, outputs follow inputs in the same cycle.
- R11: out_undef and out_valid are never high together, and out_vec is zero whenever out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the output stage |
| in_valid | input | 1 | Instruction present |
| instr | input | 32 | Instruction word |
| src_vec | input | 64 | Source vector value |
| out_valid | output | 1 | Result is valid |
| out_undef | output | 1 | Undefined encoding |
| out_dst | output | 4 | 128-bit destination register number |
| out_vec | output | 128 | Widened, shifted result |

## Verification
The bench builds the block twice, side by side, on the same stimulus. One copy uses `OUT_REG` = 1 and the other uses `OUT_REG` = 0. This puts both the same-cycle path and the registered path, including its reset state, under the same model comparison. The sweep covers:
- every legal shift for each element width;
- both extension modes;
- source patterns whose element sign bits are set.

This exposes any confusion between sign and zero extension, and any slip in lane placement. Directed words cover the refused immediates, the illegal size field and the odd destination index in both forms.

// File: rtl/wsl_pkg.sv
`timescale 1ns/1ps
package wsl_pkg;
    // Element width code: width = 8 << code
    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2
    } elem_sz_e;

    typedef struct packed {
        logic     ok;       // legal, executable
        logic     undef;    // undefined encoding
        logic     foreign;  // belongs to another operation
        logic     uns;      // zero-extend when set
        elem_sz_e sz;
        logic [5:0] shift;
        logic [3:0] dst;
    } dec_t;

    function automatic logic [5:0] width_of(elem_sz_e s);
        return 6'd8 << s;
    endfunction
endpackage

// File: rtl/wsl_decode.sv
`timescale 1ns/1ps
module wsl_decode
    import wsl_pkg::*;
(
    input  logic        in_valid,
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic       form_imm;
    logic [5:0] imm6;
    logic [2:0] top3;
    logic [1:0] size_f;
    dec_t       raw;

    assign form_imm = instr[4];
    assign imm6     = instr[21:16];
    assign top3     = imm6[5:3];
    assign size_f   = instr[19:18];

    always_comb begin
        raw       = '0;
        raw.dst   = {instr[22], instr[15:13]};
        if (form_imm) begin
            raw.foreign = (top3 == 3'b000);
            if (imm6[5])      raw.sz = SZ_W;
            else if (imm6[4]) raw.sz = SZ_H;
            else              raw.sz = SZ_B;
            raw.shift = imm6 - width_of(raw.sz);
            if (raw.shift == 6'd0) raw.foreign = 1'b1;
            raw.uns   = instr[24];
            raw.undef = !raw.foreign && instr[12];
        end else begin
            raw.foreign = 1'b0;
            if (size_f == 2'b11) begin
                raw.sz    = SZ_B;
                raw.undef = 1'b1;
            end else begin
                raw.sz    = elem_sz_e'(size_f);
                raw.undef = instr[12];
            end
            raw.shift = width_of(raw.sz);
            raw.uns   = 1'b1;
        end
        raw.ok = !raw.foreign && !raw.undef;
    end

    always_comb begin
        dec         = raw;
        dec.ok      = in_valid && raw.ok;
        dec.undef   = in_valid && raw.undef;
        dec.foreign = in_valid && raw.foreign;
    end
endmodule

// File: rtl/wsl_lane_bank.sv
`timescale 1ns/1ps
module wsl_lane_bank #(
    parameter int VEC_W  = 64,
    parameter int ELEM_W = 8
) (
    input  logic [VEC_W-1:0]   src,
    input  logic               uns,
    input  logic [5:0]         shift,
    output logic [2*VEC_W-1:0] res
);
    localparam int LANES = VEC_W / ELEM_W;
    localparam int WIDE  = 2 * ELEM_W;

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        logic [ELEM_W-1:0] elem;
        logic [WIDE-1:0]   ext;
        logic [WIDE-1:0]   shifted;
        assign elem    = src[e*ELEM_W +: ELEM_W];
        assign ext     = {{ELEM_W{~uns & elem[ELEM_W-1]}}, elem};
        assign shifted = ext << shift;
        assign res[e*WIDE +: WIDE] = shifted;
    end
endmodule

// File: rtl/widen_shift_unit.sv
`timescale 1ns/1ps
module widen_shift_unit
    import wsl_pkg::*;
#(
    parameter int VEC_W   = 64,
    parameter bit OUT_REG = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [31:0]        instr,
    input  logic [63:0]        src_vec,
    output logic               out_valid,
    output logic               out_undef,
    output logic [3:0]         out_dst,
    output logic [127:0]       out_vec
);
    localparam int NUM_SZ = 3;
    localparam int RES_W  = 2 * VEC_W;

    typedef struct packed {
        logic             valid;
        logic             undef;
        logic [3:0]       dst;
        logic [RES_W-1:0] vec;
    } out_t;

    dec_t             dec;
    logic [RES_W-1:0] bank_res [NUM_SZ];
    out_t             nxt_d;
    out_t             cur;

    wsl_decode i_dec (
        .in_valid (in_valid),
        .instr    (instr),
        .dec      (dec)
    );

    for (genvar g = 0; g < NUM_SZ; g++) begin : g_bank
        wsl_lane_bank #(.VEC_W(VEC_W), .ELEM_W(8 << g)) i_bank (
            .src   (src_vec[VEC_W-1:0]),
            .uns   (dec.uns),
            .shift (dec.shift),
            .res   (bank_res[g])
        );
    end

    always_comb begin
        nxt_d       = '0;
        nxt_d.undef = dec.undef;
        if (dec.ok) begin
            nxt_d.valid = 1'b1;
            nxt_d.dst   = dec.dst;
            nxt_d.vec   = bank_res[dec.sz];
        end
    end

    if (OUT_REG) begin : g_reg
        out_t state_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) state_q <= '0;
            else        state_q <= nxt_d;
        end
        assign cur = state_q;

        // R10
        idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && !out_undef && out_vec == '0));
    end else begin : g_comb
        assign cur = nxt_d;
    end

    assign out_valid = cur.valid;
    assign out_undef = cur.undef;
    assign out_dst   = cur.dst;
    assign out_vec   = cur.vec;

    // R11
    undef_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> (!out_valid && out_vec == '0));

    // R11
    idle_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_vec == '0));

    // R2
    foreign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec.foreign |-> (!nxt_d.valid && !nxt_d.undef));

    // R8
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_d.valid |-> ((nxt_d.vec[31:0] & ((32'd1 << dec.shift) - 32'd1)) == 32'd0));

    // R5
    max_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.ok && !instr[4]) |-> (dec.shift == (6'd8 << instr[19:18])));
endmodule

// File: tb/test_widen_shift_unit.sv
`timescale 1ns/1ps
module test_widen_shift_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vin = 1'b0;
    logic [31:0]  ins = '0;
    logic [63:0]  src = '0;
    logic         r_v, r_u, c_v, c_u;
    logic [3:0]   r_d, c_d;
    logic [127:0] r_vec, c_vec;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    widen_shift_unit #(.OUT_REG(1'b1)) i_widen_shift_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(vin), .instr(ins), .src_vec(src),
        .out_valid(r_v), .out_undef(r_u), .out_dst(r_d), .out_vec(r_vec));

    widen_shift_unit #(.OUT_REG(1'b0)) i_widen_shift_unit_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(vin), .instr(ins), .src_vec(src),
        .out_valid(c_v), .out_undef(c_u), .out_dst(c_d), .out_vec(c_vec));

    function automatic logic [31:0] imm_word(bit u, bit d, logic [5:0] imm6, logic [3:0] vd);
        return (32'(u) << 24) | (32'(d) << 22) | (32'(imm6) << 16) | (32'(vd) << 12) | 32'h10;
    endfunction

    function automatic logic [31:0] max_word(bit u, bit d, logic [1:0] sz, logic [3:0] vd);
        return (32'(u) << 24) | (32'(d) << 22) | (32'(sz) << 18) | (32'(vd) << 12);
    endfunction

    // Behavioural model built from R1..R9
    function automatic logic [133:0] model(logic v_in, logic [31:0] w, logic [63:0] s);
        int es = 8, sh = 0;
        bit uns = 1'b0, foreign = 1'b0, und = 1'b0;
        logic [127:0] r = '0;
        logic [3:0] dr = '0;
        bit ok;
        if (w[4]) begin
            if (w[21:19] == 3'b000) foreign = 1'b1;
            es = w[21] ? 32 : (w[20] ? 16 : 8);
            sh = int'(w[21:16]) - es;
            if (sh == 0) foreign = 1'b1;
            uns = w[24];
            und = !foreign && w[12];
        end else begin
            if (w[19:18] == 2'b11) und = 1'b1;
            else es = 8 << w[19:18];
            sh = es;
            und = und || w[12];
        end
        ok = v_in && !foreign && !und;
        if (ok) begin
            for (int e = 0; e < 64 / es; e++) begin
                longint elem = longint'((s >> (e * es)) & ((64'd1 << es) - 64'd1));
                logic [63:0] t;
                if (!uns && elem[es-1]) elem = elem - (longint'(1) << es);
                t = 64'(elem) << sh;
                for (int b = 0; b < 2 * es; b++) r[e * 2 * es + b] = t[b];
            end
            dr = {w[22], w[15:13]};
        end
        return {ok, v_in && und, dr, r};
    endfunction

    task automatic cmp(string tag, string path, logic [133:0] got, logic [133:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s [%s] actual=%h expected=%h", tag, path, got, exp);
        end
    endtask

    task automatic apply(logic v_in, logic [31:0] w, logic [63:0] s, string tag);
        logic [133:0] exp;
        @(negedge clk);
        vin = v_in; ins = w; src = s;
        exp = model(v_in, w, s);
        #1 cmp(tag, "same-cycle", {c_v, c_u, c_d, c_vec}, exp);
        @(negedge clk);
        cmp(tag, "registered", {r_v, r_u, r_d, r_vec}, exp);
    endtask

    localparam logic [63:0] PAT0 = 64'hF0E1_8273_9C05_A6B7;
    localparam logic [63:0] PAT1 = 64'h7F80_01FE_8001_7FFF;
    localparam logic [63:0] PAT2 = 64'hFFFF_FFFF_8000_0000;

    task automatic t_reset();
        vin = 1'b1; ins = imm_word(1'b0, 1'b0, 6'd9, 4'd0); src = PAT0;
        #2;
        cmp("R10 reset", "registered", {r_v, r_u, r_d, r_vec}, '0);
        repeat (3) @(posedge clk);
        #1 cmp("R10 reset hold", "registered", {r_v, r_u, r_d, r_vec}, '0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_imm_sweep();
        for (int g = 0; g < 3; g++) begin
            for (int k = 1; k < (8 << g); k++) begin
                for (int u = 0; u < 2; u++) begin
                    logic [5:0] imm = 6'((8 << g) + k);
                    apply(1'b1, imm_word(u[0], 1'b0, imm, 4'd2), PAT0, "R1 R4 R8 sweep a");
                    apply(1'b1, imm_word(u[0], 1'b1, imm, 4'd6), PAT1, "R1 R4 R8 sweep b");
                    apply(1'b1, imm_word(u[0], 1'b0, imm, 4'd0), PAT2, "R1 R4 sweep c");
                end
            end
        end
    endtask

    task automatic t_max_form();
        for (int sz = 0; sz < 3; sz++) begin
            apply(1'b1, max_word(1'b0, 1'b0, 2'(sz), 4'd4), PAT0, "R5 max u0");
            apply(1'b1, max_word(1'b1, 1'b0, 2'(sz), 4'd4), PAT0, "R5 max u1");
            apply(1'b1, max_word(1'b0, 1'b1, 2'(sz), 4'd8), PAT1, "R5 R8 max");
        end
    endtask

    task automatic t_foreign();
        for (int k = 0; k < 8; k++)
            apply(1'b1, imm_word(1'b0, 1'b0, 6'(k), 4'd0), PAT0, "R2 low imm");
        apply(1'b1, imm_word(1'b1, 1'b0, 6'b001000, 4'd0), PAT0, "R3 zero shift 8");
        apply(1'b1, imm_word(1'b0, 1'b0, 6'b010000, 4'd0), PAT1, "R3 zero shift 16");
        apply(1'b1, imm_word(1'b0, 1'b0, 6'b100000, 4'd1), PAT2, "R3 zero shift 32 odd vd");
    endtask

    task automatic t_undef();
        apply(1'b1, max_word(1'b0, 1'b0, 2'b11, 4'd0), PAT0, "R6 size 11");
        apply(1'b1, max_word(1'b0, 1'b1, 2'b00, 4'd3), PAT0, "R7 max odd vd");
        apply(1'b1, imm_word(1'b0, 1'b0, 6'd12, 4'd5), PAT1, "R7 imm odd vd");
        apply(1'b1, imm_word(1'b1, 1'b1, 6'd40, 4'd15), PAT2, "R7 R11 imm odd vd");
    endtask

    task automatic t_dst();
        for (int d = 0; d < 2; d++)
            for (int vd = 0; vd < 16; vd += 2)
                apply(1'b1, imm_word(1'b1, d[0], 6'd20, 4'(vd)), PAT1, "R9 dst index");
    endtask

    task automatic t_idle();
        apply(1'b0, imm_word(1'b0, 1'b0, 6'd9, 4'd0), PAT0, "R10 idle");
        apply(1'b0, max_word(1'b0, 1'b0, 2'b11, 4'd1), PAT0, "R10 idle undef word");
        apply(1'b1, imm_word(1'b0, 1'b0, 6'd33, 4'd0), PAT2, "R10 back to back");
    endtask

    initial begin
        t_reset();
        t_imm_sweep();
        t_max_form();
        t_foreign();
        t_undef();
        t_dst();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule